// File: doc/BRIEF.md
# Six-Channel Pulse Generator with Start Delay and Period Count

This block holds six pulse-width channels behind a small word-addressed register port and one clock. Each channel repeats a waveform made of a high phase followed by a low phase. Both phases are counted in clock cycles.

A channel can hold its output low for a programmable number of cycles before its first period. It can run a fixed number of periods and then park low, or it can run without end. Software may rewrite a running channel's timing at any moment. The new values take hold only when the period in progress has ended. Clearing the enable bit silences the output on the very next cycle.

Software writes the timing word first and then sets the enable bit in the control word. It clears the enable bit to stop the channel or to re-arm it after a counted run.

Top module: `pwm_bank`

## Requirements
- R1: While reset is asserted and on the first cycle after its release, every output is low and every register reads zero.
- R2: The control word of channel c (c = 0..5) is at byte address 4*c and the timing word at 0x20 + 4*c; both read back the last value written. Control bit 31 is the enable, bits 30:16 the start delay and bits 15:0 the period count. Timing bits 31:16 are the high time and bits 15:0 the low time.
- R3: Reads of any other address return zero; writes to them change no register and no output.
- R4: After the clock edge that sets the enable bit, the output stays low for 1 + start-delay cycles and then begins a high phase.
- R5: Each period drives the output high for exactly the high time and then low for exactly the low time.
- R6: With a nonzero period count N, the output stays low after N periods and the enable bit still reads 1; a count of 0 repeats without end.
- R7: After the clock edge that clears the enable bit, the output is low from the first following cycle, even in mid-period.
- R8: A timing write to a running channel leaves the current period unchanged, including its low phase; the new values govern every period that starts afterwards.
- R9: A high time of 0 keeps the output low; a low time of 0 with a nonzero high time keeps it high.
- R10: Channels are independent: a write to one channel's words changes neither the enable state nor the output of any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for all state |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe, sampled on the rising clock edge |
| addr_i | input | 8 | Byte address; bits 1:0 are ignored |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| pwm_o | output | 6 | One pulse output per channel, bit c for channel c |

## Verification
The hardest case to reach from the ports is a timing write that lands inside the high phase of a running period. In that case only a design that latches the low time at the period start finishes the period correctly. The stimulus counts clock edges from the enable write so that the new timing lands two cycles into the second high phase. It then expects one full old-shaped period before the new shape appears. A disable is likewise timed to land inside a high phase, to show that the output drops without finishing the period.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int CNT_W  = 16;
  localparam int LEAD_W = 15;

  typedef struct packed {
    logic              en;
    logic [LEAD_W-1:0] lead;
    logic [CNT_W-1:0]  reps;
  } ctrl_t;

  typedef struct packed {
    logic [CNT_W-1:0] hi;
    logic [CNT_W-1:0] lo;
  } timing_t;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LEAD,
    PH_HIGH,
    PH_LOW,
    PH_DONE
  } phase_e;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int NCH    = 6,
  parameter int ADDR_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [31:0]           wdata_i,
  output logic [31:0]           rdata_o,
  output ctrl_t   [NCH-1:0]     ctrl_o,
  output timing_t [NCH-1:0]     timing_o
);
  // Two banks of eight words: bank 0 holds control, bank 1 holds timing.
  localparam int IDX_W  = 3;
  localparam int BANK_W = ADDR_W - IDX_W - 2;
  localparam logic [BANK_W-1:0] BANK_CTRL = BANK_W'(0);
  localparam logic [BANK_W-1:0] BANK_TIM  = BANK_W'(1);

  logic [BANK_W-1:0] bank;
  logic [IDX_W-1:0]  idx;
  logic              unused_lsb;

  assign bank       = addr_i[ADDR_W-1:IDX_W+2];
  assign idx        = addr_i[IDX_W+1:2];
  assign unused_lsb = ^addr_i[1:0];

  for (genvar c = 0; c < NCH; c++) begin : g_reg
    ctrl_t   ctrl_q;
    timing_t tim_q;
    logic    ctrl_we, tim_we;

    assign ctrl_we = wr_en_i && (bank == BANK_CTRL) && (idx == IDX_W'(c));
    assign tim_we  = wr_en_i && (bank == BANK_TIM)  && (idx == IDX_W'(c));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      ctrl_q <= '0;
      else if (ctrl_we) ctrl_q <= ctrl_t'(wdata_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     tim_q <= '0;
      else if (tim_we) tim_q <= timing_t'(wdata_i);
    end

    assign ctrl_o[c]   = ctrl_q;
    assign timing_o[c] = tim_q;
  end

  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < NCH; c++) begin
      if (int'(idx) == c) begin
        if (bank == BANK_CTRL)     rdata_o = ctrl_o[c];
        else if (bank == BANK_TIM) rdata_o = timing_o[c];
      end
    end
  end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [LEAD_W-1:0] lead_i,
  input  logic [CNT_W-1:0]  reps_i,
  input  logic [CNT_W-1:0]  hi_i,
  input  logic [CNT_W-1:0]  lo_i,
  output logic              pwm_o
);
  phase_e           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] per_q, per_d;
  logic [CNT_W-1:0] lo_q, lo_d;

  // Values a new period starts from, taken from the staged timing word.
  phase_e           st_ph;
  logic [CNT_W-1:0] st_cnt;
  logic [CNT_W-1:0] per_inc;
  logic             last_per;

  assign st_ph    = (hi_i != '0) ? PH_HIGH : PH_LOW;
  assign st_cnt   = (hi_i != '0) ? hi_i - 1'b1 :
                    (lo_i != '0) ? lo_i - 1'b1 : '0;
  assign per_inc  = per_q + 1'b1;
  assign last_per = (reps_i != '0) && (per_inc == reps_i);

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    per_d = per_q;
    lo_d  = lo_q;
    if (!en_i) begin
      ph_d  = PH_IDLE;
      cnt_d = '0;
      per_d = '0;
      lo_d  = '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: begin
          if (lead_i != '0) begin
            ph_d  = PH_LEAD;
            cnt_d = {1'b0, lead_i} - 1'b1;
          end else begin
            ph_d  = st_ph;
            cnt_d = st_cnt;
            lo_d  = lo_i;
          end
        end
        PH_LEAD: begin
          if (cnt_q == '0) begin
            ph_d  = st_ph;
            cnt_d = st_cnt;
            lo_d  = lo_i;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        PH_HIGH, PH_LOW: begin
          if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
          end else if (ph_q == PH_HIGH && lo_q != '0) begin
            ph_d  = PH_LOW;
            cnt_d = lo_q - 1'b1;
          end else begin
            per_d = per_inc;
            if (last_per) begin
              ph_d = PH_DONE;
            end else begin
              ph_d  = st_ph;
              cnt_d = st_cnt;
              lo_d  = lo_i;
            end
          end
        end
        PH_DONE: ph_d = PH_DONE;
        default: ph_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      per_q <= '0;
      lo_q  <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      per_q <= per_d;
      lo_q  <= lo_d;
    end
  end

  // The enable gates the output so that a disable acts without waiting a cycle.
  assign pwm_o = en_i && (ph_q == PH_HIGH);
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_pkg::*;
#(
  parameter int NCH    = 6,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [NCH-1:0]    pwm_o
);
  ctrl_t   [NCH-1:0] ctrl;
  timing_t [NCH-1:0] timing;
  logic    [NCH-1:0] en_vec;

  pwm_regs #(.NCH(NCH), .ADDR_W(ADDR_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .ctrl_o  (ctrl),
    .timing_o(timing)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign en_vec[c] = ctrl[c].en;

    pwm_chan u_chan (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (ctrl[c].en),
      .lead_i(ctrl[c].lead),
      .reps_i(ctrl[c].reps),
      .hi_i  (timing[c].hi),
      .lo_i  (timing[c].lo),
      .pwm_o (pwm_o[c])
    );
  end
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
  parameter int NCH    = 6,
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [NCH-1:0]    en_i,
  input logic [NCH-1:0]    pwm_i
);
  logic unmapped;
  assign unmapped = (addr_i[ADDR_W-1:5] > (ADDR_W-5)'(1)) || (int'(addr_i[4:2]) >= NCH);

  // R1: outputs are quiet on the first cycle out of reset
  a_r1_quiet_after_reset: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (pwm_i == '0));

  // R3: a write to an unmapped address leaves every enable unchanged
  a_r3_unmapped_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && unmapped) |=> $stable(en_i));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    // R4: the cycle right after an enable is always low
    a_r4_start_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(en_i[c]) |-> !pwm_i[c]);

    // R7: the output is low in the cycle a disable takes effect
    a_r7_stop_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(en_i[c]) |-> !pwm_i[c]);

    // R10: writes aimed elsewhere leave this channel's enable alone
    a_r10_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && (addr_i[ADDR_W-1:2] != (ADDR_W-2)'(c))) |=> $stable(en_i[c]));
  end
endmodule

bind pwm_bank pwm_bank_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .wr_en_i(wr_en_i),
  .addr_i (addr_i),
  .en_i   (en_vec),
  .pwm_i  (pwm_o)
);

// File: tb/sim_pwm_bank.sv
module sim_pwm_bank;
  localparam int NCH = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [NCH-1:0] pwm;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    finished = 0;
  string cur_tag = "R1";
  logic [NCH-1:0] exp_q[$];

  always #10 clk = ~clk;

  pwm_bank #(.NCH(NCH), .ADDR_W(8)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pwm_o(pwm)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  function automatic logic [31:0] ctl(input bit en, input int lead, input int reps);
    return {en, 15'(lead), 16'(reps)};
  endfunction

  function automatic logic [31:0] tim(input int hi, input int lo);
    return {16'(hi), 16'(lo)};
  endfunction

  // Driver side: predict one channel's output sample by sample and merge it into the queue.
  task automatic plan(input int ch, input int off, input int pre, input int hi,
                      input int lo, input int reps, input int len);
    for (int i = 0; i < len; i++) begin
      logic b;
      int   j;
      b = 1'b0;
      if (i >= pre && (hi + lo) != 0) begin
        j = i - pre;
        if (reps == 0 || (j / (hi + lo)) < reps) b = ((j % (hi + lo)) < hi);
      end
      while (exp_q.size() <= off + i) exp_q.push_back('0);
      exp_q[off + i][ch] = b;
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] expv, input string tag);
    addr = a;
    #1;
    check(rdata == expv, tag, rdata, expv);
    @(negedge clk);
  endtask

  task automatic drain;
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  // Monitor side: one expected output vector per cycle, sampled after the edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [NCH-1:0] e;
        e = exp_q.pop_front();
        check(pwm == e, cur_tag, 32'(pwm), 32'(e));
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    check(pwm == '0, "R1", 32'(pwm), 0);
    rd(8'h00, 0, "R1");
    rd(8'h24, 0, "R1");
    rst_n = 1'b1;
    @(negedge clk);
    check(pwm == '0, "R1", 32'(pwm), 0);

    // R5 R6: three counted periods on channel 0
    wr(8'h20, tim(3, 2));
    cur_tag = "R5";
    plan(0, 0, 1, 3, 2, 3, 22);
    wr(8'h00, ctl(1, 0, 3));
    drain();
    rd(8'h00, ctl(1, 0, 3), "R6");
    rd(8'h20, tim(3, 2), "R2");
    wr(8'h00, 0);

    // R4: start delay on channel 2
    wr(8'h28, tim(2, 2));
    cur_tag = "R4";
    plan(2, 0, 5, 2, 2, 1, 14);
    wr(8'h08, ctl(1, 4, 1));
    drain();
    rd(8'h08, ctl(1, 4, 1), "R2");
    wr(8'h08, 0);

    // R9: zero high time on channel 1 stays low
    wr(8'h24, tim(0, 4));
    cur_tag = "R9";
    plan(1, 0, 1, 0, 4, 0, 12);
    wr(8'h04, ctl(1, 0, 0));
    drain();
    wr(8'h04, 0);

    // R9: zero low time on channel 3 stays high, then R7 stop
    wr(8'h2C, tim(3, 0));
    cur_tag = "R9";
    plan(3, 0, 1, 3, 0, 0, 12);
    wr(8'h0C, ctl(1, 0, 0));
    drain();
    cur_tag = "R7";
    plan(3, 0, 0, 0, 1, 0, 4);
    wr(8'h0C, 0);
    drain();

    // R8: timing rewritten during the second high phase of channel 4
    wr(8'h30, tim(3, 2));
    cur_tag = "R8";
    plan(4, 0, 1, 3, 2, 0, 11);
    plan(4, 11, 0, 1, 1, 0, 8);
    wr(8'h10, ctl(1, 0, 0));
    repeat (6) @(negedge clk);
    wr(8'h30, tim(1, 1));
    drain();
    cur_tag = "R7";
    plan(4, 0, 0, 0, 1, 0, 3);
    wr(8'h10, 0);
    drain();

    // R7: disable lands inside a high phase of channel 5
    wr(8'h34, tim(5, 5));
    cur_tag = "R7";
    plan(5, 0, 1, 5, 5, 0, 4);
    wr(8'h14, ctl(1, 0, 0));
    drain();
    plan(5, 0, 0, 0, 1, 0, 6);
    wr(8'h14, 0);
    drain();
    // R4 R6: re-arm with a delay and a count of two
    wr(8'h34, tim(2, 1));
    cur_tag = "R6";
    plan(5, 0, 4, 2, 1, 2, 15);
    wr(8'h14, ctl(1, 3, 2));
    drain();
    rd(8'h14, ctl(1, 3, 2), "R6");
    wr(8'h14, 0);
    rd(8'h14, 0, "R2");

    // R10: two channels running side by side
    wr(8'h24, tim(1, 1));
    wr(8'h28, tim(2, 1));
    cur_tag = "R10";
    plan(1, 0, 1, 1, 1, 4, 12);
    plan(2, 1, 1, 2, 1, 2, 10);
    wr(8'h04, ctl(1, 0, 4));
    wr(8'h08, ctl(1, 0, 2));
    drain();
    rd(8'h04, ctl(1, 0, 4), "R10");
    rd(8'h00, 0, "R10");
    wr(8'h04, 0);
    wr(8'h08, 0);

    // R3: unmapped addresses
    cur_tag = "R3";
    plan(0, 0, 0, 0, 1, 0, 8);
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h3C, 32'hFFFF_FFFF);
    wr(8'h80, 32'hFFFF_FFFF);
    wr(8'h44, 32'hFFFF_FFFF);
    drain();
    rd(8'h18, 0, "R3");
    rd(8'h3C, 0, "R3");
    rd(8'h80, 0, "R3");
    rd(8'h44, 0, "R3");
    rd(8'h00, 0, "R3");
    rd(8'h20, tim(3, 2), "R3");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule